// File: doc/BRIEF.md
# ATA PIO Host Cycle Sequencer

This block runs one programmed-I/O register access toward a single ATA/IDE device channel for each request it accepts. It places the two active-low device selects and the 3-bit register address on the bus, then drops either the read strobe or the write strobe. On a write it drives the 16-bit data bus. On a read it leaves the bus released and captures the device's data. Every phase length is a clock count taken from a configuration input. A count of zero is treated as one.

A set number of strobe cycles after the strobe falls, the block looks once at the synchronised device ready line. If ready is high at that moment, the strobe lasts a fixed number of cycles. If ready is low, the strobe stays low until ready is seen high again, and read data is captured on that edge. If ready stays low past a programmable limit, the cycle is cut short, a sticky timeout flag is raised and the read result is all ones. The host side is a valid/ready request port. A one-cycle done pulse carries the result, and the next request is taken only after the recovery count has run out.

Top module: `ata_pio_seq`

## Requirements
- R1: While reset is low, and just after it, both strobes are high, `dev_cs_n` is 2'b11, `dev_data_oe` is 0, `req_ready` is 1, and both `done` and `timeout_flag` are 0.
- R2: `dev_cs_n` equals the bitwise inverse of the request's `req_cs`, and `dev_addr` equals `req_addr`. Both are valid for exactly max(`cfg_setup`,1) cycles before the strobe falls, stay stable while the strobe is low, and are held for exactly max(`cfg_hold`,1) cycles after it rises. Then `dev_cs_n` returns to 2'b11.
- R3: A read (`req_write`=0) pulls only `dev_rd_n` low, and a write (`req_write`=1) pulls only `dev_wr_n` low. The two strobes are never low together.
- R4: Ready is sampled in strobe cycle number max(`cfg_sample`,1), counting the first low cycle as 1. If ready is high there, the strobe is low for exactly max(`cfg_active`,`cfg_sample`,1) cycles.
- R5: If ready is low at the sample point, the strobe stays low until the synchronised ready is high and at least max(`cfg_active`,1) strobe cycles have passed. With its two-flop synchroniser, the strobe rises after the third rising clock edge that follows the rise of `dev_iordy`.
- R6: When ready goes low and comes back high early enough that the synchronised value is already high at the sample point, no wait is inserted.
- R7: `done` is a one-cycle pulse in the first cycle after the hold phase. For a read, `done_rdata` holds `dev_data_in` as captured on the last strobe cycle. On a waited read, that is the cycle in which the synchronised ready is seen high.
- R8: On a write, `dev_data_oe` is 1 during every strobe cycle and every hold cycle, and 0 otherwise. `dev_data_out` carries `req_wdata`. On a read, `dev_data_oe` stays 0.
- R9: If ready is still low after max(`cfg_wait_max`,1) wait cycles, the strobe rises after max(`cfg_sample`,1)+max(`cfg_wait_max`,1) low cycles. `done_rdata` is then 16'hFFFF, and `timeout_flag` goes to 1 and stays there until reset.
- R10: `req_ready` is low from the accepting edge until max(`cfg_recover`,1) cycles after the hold phase ends, counting the `done` cycle. No request is accepted while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_setup | input | 8 | Address setup cycles before strobe |
| cfg_active | input | 8 | Minimum strobe low cycles |
| cfg_sample | input | 8 | Strobe cycle at which ready is sampled |
| cfg_hold | input | 8 | Address and write data hold cycles after strobe |
| cfg_recover | input | 8 | Recovery cycles before the next request |
| cfg_wait_max | input | 12 | Wait cycles before timeout |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Device select pair, active high |
| req_addr | input | 3 | Device register address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 16 | Captured read data, all ones after timeout |
| timeout_flag | output | 1 | Sticky timeout indication |
| dev_cs_n | output | 2 | Device selects, active low |
| dev_addr | output | 3 | Device register address |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_data_out | output | 16 | Data bus output value |
| dev_data_oe | output | 1 | Data bus output enable |
| dev_data_in | input | 16 | Data bus input value |
| dev_iordy | input | 1 | Device ready, high when released |

## Verification
The hardest cases to reach depend on when `dev_iordy` moves relative to the sample point, counted through the two synchroniser flops.

The bench's device model lowers ready before the request. It then raises ready in a chosen strobe cycle, so one run can:
- land just early enough to avoid a wait,
- enter the wait only to leave it in the same cycle the unwaited strobe would have ended,
- wait several cycles.

On waited reads, the model presents the true data only when it raises ready. A capture taken too early therefore shows up as the wrong value. The timeout case runs last, with ready never raised, and a following access confirms that the flag is sticky.

// File: rtl/ata_pio_pkg.sv
// Shared types for the ATA PIO host cycle sequencer.
package ata_pio_pkg;

    // Phase of one programmed-I/O cycle; order matches the cycle's progress.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_WAIT   = 3'd3,
        ST_HOLD   = 3'd4,
        ST_RECOV  = 3'd5
    } pio_state_t;

endpackage

// File: rtl/pio_rdy_sync.sv
// Multi-flop synchroniser for the device ready input.
// Assumes the input may change at any time relative to clk; the flops reset
// to 1 so that a released (pulled-up) line reads as ready from reset on.
module pio_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pio_phase_fsm.sv
// Phase controller: walks setup, strobe, optional wait, hold and recovery,
// timing each phase with one shared cycle counter and the wait with a second.
// Assumes rdy_s is already synchronised. Zero configuration counts act as 1.
module pio_phase_fsm
    import ata_pio_pkg::*;
#(
    parameter int CW = 8,
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rdy_s,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_active,
    input  logic [CW-1:0] cfg_sample,
    input  logic [CW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_recover,
    input  logic [TW-1:0] cfg_wait_max,
    output pio_state_t    state,
    output logic          cap_now,
    output logic          to_evt,
    output logic          fin
);
    localparam logic [CW:0] ONE_C = {{CW{1'b0}}, 1'b1};
    localparam logic [TW:0] ONE_T = {{TW{1'b0}}, 1'b1};

    pio_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [TW-1:0] wcnt_q;
    logic          clr_cnt;
    logic [CW:0]   cnt_p1, s_eff, w_eff, a_eff, h_eff, r_eff, end_w;
    logic [TW:0]   wcnt_p1, m_eff;

    // Clamp a zero count to one.
    function automatic logic [CW:0] eff_c(input logic [CW-1:0] v);
        return (v == '0) ? ONE_C : {1'b0, v};
    endfunction

    function automatic logic [TW:0] eff_t(input logic [TW-1:0] v);
        return (v == '0) ? ONE_T : {1'b0, v};
    endfunction

    // Effective phase lengths and incremented counters.
    always_comb begin
        s_eff   = eff_c(cfg_setup);
        w_eff   = eff_c(cfg_active);
        a_eff   = eff_c(cfg_sample);
        h_eff   = eff_c(cfg_hold);
        r_eff   = eff_c(cfg_recover);
        m_eff   = eff_t(cfg_wait_max);
        end_w   = (a_eff > w_eff) ? a_eff : w_eff;
        cnt_p1  = {1'b0, cnt_q} + ONE_C;
        wcnt_p1 = {1'b0, wcnt_q} + ONE_T;
    end

    // Next-phase decision and one-cycle event strobes.
    always_comb begin
        state_d = state_q;
        clr_cnt = 1'b0;
        cap_now = 1'b0;
        to_evt  = 1'b0;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clr_cnt = 1'b1;
                if (start) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (cnt_p1 >= s_eff) begin
                    state_d = ST_STROBE;
                    clr_cnt = 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt_p1 == a_eff && !rdy_s) begin
                    state_d = ST_WAIT;
                end else if (cnt_p1 >= end_w) begin
                    state_d = ST_HOLD;
                    cap_now = 1'b1;
                    clr_cnt = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rdy_s && cnt_p1 >= w_eff) begin
                    state_d = ST_HOLD;
                    cap_now = 1'b1;
                    clr_cnt = 1'b1;
                end else if (wcnt_p1 >= m_eff) begin
                    state_d = ST_HOLD;
                    to_evt  = 1'b1;
                    clr_cnt = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_p1 >= h_eff) begin
                    state_d = ST_RECOV;
                    fin     = 1'b1;
                    clr_cnt = 1'b1;
                end
            end
            ST_RECOV: begin
                if (cnt_p1 >= r_eff) begin
                    state_d = ST_IDLE;
                    clr_cnt = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                clr_cnt = 1'b1;
            end
        endcase
    end

    // Phase register and saturating phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clr_cnt)         cnt_q <= '0;
            else if (!cnt_p1[CW]) cnt_q <= cnt_p1[CW-1:0];
        end
    end

    // Wait-length counter, running only while in the wait phase.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_WAIT) wcnt_q <= '0;
        else if (!wcnt_p1[TW])            wcnt_q <= wcnt_p1[TW-1:0];
    end

    assign state = state_q;
endmodule

// File: rtl/pio_bus_regs.sv
// Bus side registers: holds the accepted request, decodes device pins from
// the phase, captures read data and keeps the done pulse and sticky flag.
// Assumes phase and event inputs come from pio_phase_fsm in the same clock.
module pio_bus_regs
    import ata_pio_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 3,
    parameter int NCS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           req_write,
    input  logic [NCS-1:0] req_cs,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  pio_state_t     state,
    input  logic           cap_now,
    input  logic           to_evt,
    input  logic           fin,
    input  logic [DW-1:0]  dev_data_in,
    output logic [NCS-1:0] dev_cs_n,
    output logic [AW-1:0]  dev_addr,
    output logic           dev_rd_n,
    output logic           dev_wr_n,
    output logic [DW-1:0]  dev_data_out,
    output logic           dev_data_oe,
    output logic           done,
    output logic [DW-1:0]  done_rdata,
    output logic           timeout_flag
);
    logic           wr_q;
    logic [NCS-1:0] cs_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q, rdata_q;
    logic           done_q, to_q;
    logic           in_addr, in_strobe, in_drive;

    // Latch the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            cs_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            wr_q    <= req_write;
            cs_q    <= req_cs;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture read data at strobe end, or force all ones on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (cap_now) rdata_q <= dev_data_in;
        else if (to_evt)  rdata_q <= '1;
    end

    // Completion pulse and sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            done_q <= fin;
            to_q   <= to_q | to_evt;
        end
    end

    // Phase decode for the device pins.
    always_comb begin
        in_strobe = (state == ST_STROBE) || (state == ST_WAIT);
        in_drive  = in_strobe || (state == ST_HOLD);
        in_addr   = in_drive || (state == ST_SETUP);
    end

    assign dev_cs_n     = in_addr ? ~cs_q : '1;
    assign dev_addr     = addr_q;
    assign dev_rd_n     = ~(in_strobe & ~wr_q);
    assign dev_wr_n     = ~(in_strobe & wr_q);
    assign dev_data_out = wdata_q;
    assign dev_data_oe  = wr_q & in_drive;
    assign done         = done_q;
    assign done_rdata   = rdata_q;
    assign timeout_flag = to_q;
endmodule

// File: rtl/ata_pio_seq.sv
// Top of the ATA PIO host cycle sequencer: one register access per accepted
// request. Assumes a single device channel and an externally pulled-up ready.
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int CW = 8,
    parameter int TW = 12,
    parameter int DW = 16,
    parameter int AW = 3,
    parameter int NCS = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cfg_setup,
    input  logic [CW-1:0]  cfg_active,
    input  logic [CW-1:0]  cfg_sample,
    input  logic [CW-1:0]  cfg_hold,
    input  logic [CW-1:0]  cfg_recover,
    input  logic [TW-1:0]  cfg_wait_max,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_write,
    input  logic [NCS-1:0] req_cs,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           done,
    output logic [DW-1:0]  done_rdata,
    output logic           timeout_flag,
    output logic [NCS-1:0] dev_cs_n,
    output logic [AW-1:0]  dev_addr,
    output logic           dev_rd_n,
    output logic           dev_wr_n,
    output logic [DW-1:0]  dev_data_out,
    output logic           dev_data_oe,
    input  logic [DW-1:0]  dev_data_in,
    input  logic           dev_iordy
);
    pio_state_t state;
    logic       rdy_s, start, cap_now, to_evt, fin;

    assign req_ready = (state == ST_IDLE);
    assign start     = req_valid & req_ready;

    pio_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(dev_iordy), .dout(rdy_s)
    );

    pio_phase_fsm #(.CW(CW), .TW(TW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .rdy_s(rdy_s),
        .cfg_setup(cfg_setup), .cfg_active(cfg_active),
        .cfg_sample(cfg_sample), .cfg_hold(cfg_hold),
        .cfg_recover(cfg_recover), .cfg_wait_max(cfg_wait_max),
        .state(state), .cap_now(cap_now), .to_evt(to_evt), .fin(fin)
    );

    pio_bus_regs #(.DW(DW), .AW(AW), .NCS(NCS)) u_bus (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr),
        .req_wdata(req_wdata), .state(state), .cap_now(cap_now),
        .to_evt(to_evt), .fin(fin), .dev_data_in(dev_data_in),
        .dev_cs_n(dev_cs_n), .dev_addr(dev_addr), .dev_rd_n(dev_rd_n),
        .dev_wr_n(dev_wr_n), .dev_data_out(dev_data_out),
        .dev_data_oe(dev_data_oe), .done(done), .done_rdata(done_rdata),
        .timeout_flag(timeout_flag)
    );
endmodule

// File: rtl/pio_seq_checker.sv
// Port-level temporal checks for ata_pio_seq, attached with bind below.
module pio_seq_checker #(
    parameter int AW = 3,
    parameter int NCS = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_ready,
    input logic           done,
    input logic           timeout_flag,
    input logic [NCS-1:0] dev_cs_n,
    input logic [AW-1:0]  dev_addr,
    input logic           dev_rd_n,
    input logic           dev_wr_n,
    input logic           dev_data_oe
);
    // R3: the two strobes are never low together.
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_rd_n && !dev_wr_n));

    // R2: selects and address stay put while the strobe is low.
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((!dev_rd_n || !dev_wr_n) && (!$past(dev_rd_n) || !$past(dev_wr_n)))
        |-> ($stable(dev_addr) && $stable(dev_cs_n)));

    // R8: a write strobe always has the bus driven, a read strobe never.
    a_r8_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_wr_n |-> dev_data_oe);
    a_r8_oe_read: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rd_n |-> !dev_data_oe);

    // R7: done lasts one cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: timeout flag is sticky.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |=> timeout_flag);

    // R10: while accepting, the device bus is idle.
    a_r10_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dev_rd_n && dev_wr_n && dev_cs_n == '1 && !dev_data_oe));
endmodule

bind ata_pio_seq pio_seq_checker #(.AW(AW), .NCS(NCS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
    .timeout_flag(timeout_flag), .dev_cs_n(dev_cs_n), .dev_addr(dev_addr),
    .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_data_oe(dev_data_oe)
);

// File: tb/sim_ata_pio_seq.sv
module sim_ata_pio_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_setup, cfg_active, cfg_sample, cfg_hold, cfg_recover;
    logic [11:0] cfg_wait_max;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_cs = 2'b01;
    logic [2:0]  req_addr = 3'd0;
    logic [15:0] req_wdata = 16'h0, dev_data_in = 16'h0;
    logic        dev_iordy = 1'b1;
    logic        req_ready, done, timeout_flag, dev_rd_n, dev_wr_n, dev_data_oe;
    logic [15:0] done_rdata, dev_data_out;
    logic [1:0]  dev_cs_n;
    logic [2:0]  dev_addr;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ata_pio_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_active(cfg_active),
        .cfg_sample(cfg_sample), .cfg_hold(cfg_hold), .cfg_recover(cfg_recover),
        .cfg_wait_max(cfg_wait_max), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .done_rdata(done_rdata),
        .timeout_flag(timeout_flag), .dev_cs_n(dev_cs_n), .dev_addr(dev_addr),
        .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_data_out(dev_data_out),
        .dev_data_oe(dev_data_oe), .dev_data_in(dev_data_in), .dev_iordy(dev_iordy)
    );

    typedef struct packed {
        logic              wr;
        logic [1:0]        cs;
        logic [2:0]        ad;
        logic [15:0]       wd;
        logic [15:0]       rd;
        logic              pre;
        logic signed [7:0] rise;
        logic [7:0]        expw;
    } vec_t;

    // Timing for the table: setup 2, active 4, sample 3, hold 2, recover 3.
    localparam vec_t VEC [6] = '{
        '{1'b0, 2'b01, 3'd7, 16'h0000, 16'hA5A5, 1'b1, -8'sd1, 8'd4}, // R4 read
        '{1'b1, 2'b10, 3'd2, 16'h1234, 16'h0000, 1'b1, -8'sd1, 8'd4}, // R4 write
        '{1'b0, 2'b10, 3'd1, 16'h0000, 16'h5A0F, 1'b0,  8'sd5, 8'd8}, // R5 waited read
        '{1'b1, 2'b01, 3'd6, 16'hBEEF, 16'h0000, 1'b0,  8'sd3, 8'd6}, // R5 waited write
        '{1'b0, 2'b11, 3'd3, 16'h0000, 16'h0F0F, 1'b0,  8'sd0, 8'd4}, // R6 early return
        '{1'b0, 2'b01, 3'd4, 16'h0000, 16'hC3C3, 1'b0,  8'sd1, 8'd4}  // R5 wait exits at min
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int s, input int w, input int a, input int h,
                           input int r, input int m);
        cfg_setup = 8'(s); cfg_active = 8'(w); cfg_sample = 8'(a);
        cfg_hold = 8'(h); cfg_recover = 8'(r); cfg_wait_max = 12'(m);
    endtask

    function automatic int one(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Runs one access with a device model and checks all phase lengths.
    task automatic run_txn(input logic wr, input logic [1:0] cs, input logic [2:0] ad,
                           input logic [15:0] wd, input logic [15:0] rd,
                           input logic pre, input int rise, input int expw,
                           input logic exp_to, input logic [15:0] exp_rd);
        int setup_n = 0, w = 0, hold_n = 0, oe_n = 0, rec = 0, wrong = 0;
        bit seen = 0;
        logic [15:0] got = 16'h0;
        dev_iordy = pre;
        dev_data_in = (rise >= 0) ? 16'h0BAD : rd;
        repeat (4) @(negedge clk);
        req_write = wr; req_cs = cs; req_addr = ad; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 400 && !seen; c++) begin
            if (!dev_rd_n || !dev_wr_n) begin
                w++;
                if (wr ? !dev_rd_n : !dev_wr_n) wrong++;
                if (dev_addr != ad || dev_cs_n != ~cs) wrong++;
                if (wr && dev_data_out != wd) wrong++;
                if (rise >= 0 && w - 1 == rise) begin
                    dev_iordy = 1'b1;
                    dev_data_in = rd;
                end
            end else if (dev_cs_n == ~cs) begin
                if (dev_addr != ad) wrong++;
                if (w == 0) setup_n++; else hold_n++;
            end
            if (dev_data_oe) oe_n++;
            if (done) begin
                seen = 1;
                got = done_rdata;
            end
            @(negedge clk);
        end
        check("R7 done seen", int'(seen), 1);
        check("R7 done one cycle", int'(done), 0);
        check("R2 setup cycles", setup_n, one(int'(cfg_setup)));
        check("R2 hold cycles", hold_n, one(int'(cfg_hold)));
        check("R3 strobe, address and data match", wrong, 0);
        check("R4/R5/R9 strobe width", w, expw);
        check("R8 oe cycles", oe_n, wr ? expw + one(int'(cfg_hold)) : 0);
        if (!wr || exp_to) check("R7 read data", int'(got), int'(exp_rd));
        check("R9 timeout flag", int'(timeout_flag), int'(exp_to));
        rec = 1;
        while (!req_ready && rec < 100) begin
            rec++;
            @(negedge clk);
        end
        check("R10 recovery cycles", rec, one(int'(cfg_recover)));
        dev_iordy = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        set_cfg(2, 4, 3, 2, 3, 20);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rd_n", int'(dev_rd_n), 1);
        check("R1 wr_n", int'(dev_wr_n), 1);
        check("R1 cs_n", int'(dev_cs_n), 3);
        check("R1 oe", int'(dev_data_oe), 0);
        check("R1 done", int'(done), 0);
        check("R1 timeout", int'(timeout_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", int'(req_ready), 1);

        foreach (VEC[i]) begin
            run_txn(VEC[i].wr, VEC[i].cs, VEC[i].ad, VEC[i].wd, VEC[i].rd,
                    VEC[i].pre, int'(VEC[i].rise), int'(VEC[i].expw),
                    1'b0, VEC[i].rd);
        end

        // R10: a held request waits for the recovery to end (one access only)
        set_cfg(1, 2, 1, 1, 4, 20);
        run_txn(1'b0, 2'b01, 3'd5, 16'h0, 16'h7777, 1'b1, -1, 2, 1'b0, 16'h7777);

        // R4 with zero counts: every phase becomes one cycle
        set_cfg(0, 0, 0, 0, 0, 20);
        run_txn(1'b0, 2'b10, 3'd0, 16'h0, 16'h1111, 1'b1, -1, 1, 1'b0, 16'h1111);
        run_txn(1'b1, 2'b01, 3'd3, 16'h2222, 16'h0, 1'b1, -1, 1, 1'b0, 16'h0);

        // R5 sampled in the first strobe cycle, ready back in cycle 2
        set_cfg(1, 1, 1, 1, 1, 20);
        run_txn(1'b0, 2'b01, 3'd2, 16'h0, 16'h3C3C, 1'b0, 2, 5, 1'b0, 16'h3C3C);

        // R9 timeout: sample 3 plus limit 5 gives width 8
        set_cfg(2, 4, 3, 2, 3, 5);
        run_txn(1'b0, 2'b10, 3'd6, 16'h0, 16'h4444, 1'b0, -1, 8, 1'b1, 16'hFFFF);
        // R9 sticky: a later normal access keeps the flag set
        run_txn(1'b0, 2'b01, 3'd1, 16'h0, 16'h9999, 1'b1, -1, 4, 1'b1, 16'h9999);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule